// File: doc/BRIEF.md
# Watchdog and Interval Timer

An 8-bit up-counter that advances on single-cycle count-enable pulses while it is enabled. When the counter wraps from its all-ones value to zero, it sets an overflow flag. What happens next depends on the mode. In interval mode, a level interrupt request follows the flag. In watchdog mode, the block sends a one-cycle reset request if reset is enabled, and a one-cycle non-maskable interrupt request if it is not.

Software reaches the block over a small register bus with two addresses: the counter and the control/status word. Clearing the overflow flag is protected. A write of 0 to the flag only takes effect after a read of the control/status word has returned the flag as 1.

Top module: `wdog_itmr`

## Requirements
- R1: After reset, the counter and the control/status word read 0x00, and `irq_o`, `nmi_o` and `rst_req_o` are low.
- R2: The counter increases by one on each clock where `tick_i` is high and the enable bit is 1. In every other case it keeps its value.
- R3: A bus write to address 0 loads the counter. A load takes priority over counting in the same cycle and does not produce an overflow.
- R4: When the counter wraps from 0xFF to 0x00, the overflow flag (control/status bit 7) becomes 1 on the next clock.
- R5: A control/status write with bit 7 at 0 clears the flag only if an earlier control/status read returned bit 7 as 1. Every control/status write drops that armed state. Writing 1 to bit 7 never sets the flag.
- R6: A control/status read in the same cycle as the wrap that sets the flag returns bit 7 as 0 and does not arm the clear.
- R7: A flag set event overrides any clear in the same cycle, so the flag stays 1.
- R8: A control/status write with the enable bit (bit 5) at 0 clears the flag without any prior read.
- R9: With the mode bit (bit 6) at 0, `irq_o` is high exactly while the flag is 1. With the mode bit at 1, `irq_o` stays low.
- R10: With the mode bit at 1 and reset-enable (bit 4) at 1, an overflow gives a one-cycle `rst_req_o` pulse in the cycle the flag sets. The flag is cleared on the following clock.
- R11: With the mode bit at 1 and reset-enable at 0, an overflow gives a one-cycle `nmi_o` pulse in the cycle the flag sets. The flag stays 1.
- R12: Address 0 is the counter and address 1 is the control/status word. Bits 3:0 of the control/status word read as 0. Bits 6:4 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable pulse from the prescaler |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | 1 | 0 selects the counter, 1 selects control/status |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data, combinational from the current state |
| irq_o | output | 1 | Interval overflow interrupt request, level |
| nmi_o | output | 1 | Watchdog non-maskable interrupt request, one-cycle pulse |
| rst_req_o | output | 1 | Watchdog internal reset request, one-cycle pulse |

## Verification
The assertions assume that a bus access lasts one cycle. They also assume that a read takes `rdata_o` in the same cycle it is presented, and that `tick_i` is a synchronous pulse. The bench drives all inputs on the falling edge and keeps every access to a single cycle. It sweeps all 256 counter start values with varying pulse counts, so that wraps happen both once and several times. The same-cycle corner cases (a set event colliding with a read, with a clear write, or with a disable write) are built by driving the bus and `tick_i` together on one falling edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned FLAG_BIT  = 7;
  localparam int unsigned MODE_BIT  = 6;
  localparam int unsigned EN_BIT    = 5;
  localparam int unsigned RSTEN_BIT = 4;
  localparam logic ADDR_CNT  = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef struct packed {
    logic mode;   // 1: watchdog, 0: interval
    logic en;
    logic rst_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = run_i && !ld_i && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/wdog_flag.sv
module wdog_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_flag_i,
  input  logic dis_i,
  input  logic auto_clr_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, armed_q, sw_clr;

  assign sw_clr = wr_i && !wr_flag_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      // set outranks every clear source
      if (set_i)                             flag_q <= 1'b1;
      else if (sw_clr || dis_i || auto_clr_i) flag_q <= 1'b0;
      // arm only on a read that sees the flag already set
      if (wr_i)                 armed_q <= 1'b0;
      else if (rd_i && flag_q)  armed_q <= 1'b1;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/wdog_req.sv
module wdog_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic flag_i,
  input  logic mode_i,
  input  logic rst_en_i,
  output logic irq_o,
  output logic nmi_o,
  output logic rst_req_o
);
  logic rst_q, nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      rst_q <= ovf_i && mode_i && rst_en_i;
      nmi_q <= ovf_i && mode_i && !rst_en_i;
    end
  end

  assign rst_req_o = rst_q;
  assign nmi_o     = nmi_q;
  assign irq_o     = flag_i && !mode_i;
endmodule

// File: rtl/wdog_itmr.sv
module wdog_itmr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             rst_req_o
);
  import wdog_pkg::*;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt, ctrl_word;
  logic             cnt_wr, ctrl_wr, ctrl_rd, wrap, flag, armed;

  assign cnt_wr  = req_i && we_i  && (addr_i == ADDR_CNT);
  assign ctrl_wr = req_i && we_i  && (addr_i == ADDR_CTRL);
  assign ctrl_rd = req_i && !we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_wr) begin
      ctrl_q.mode   <= wdata_i[MODE_BIT];
      ctrl_q.en     <= wdata_i[EN_BIT];
      ctrl_q.rst_en <= wdata_i[RSTEN_BIT];
    end
  end

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q.en && tick_i),
    .ld_i     (cnt_wr),
    .ld_val_i (wdata_i),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  wdog_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (wrap),
    .rd_i       (ctrl_rd),
    .wr_i       (ctrl_wr),
    .wr_flag_i  (wdata_i[FLAG_BIT]),
    .dis_i      (ctrl_wr && !wdata_i[EN_BIT]),
    .auto_clr_i (rst_req_o),
    .flag_o     (flag),
    .armed_o    (armed)
  );

  wdog_req u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_i     (wrap),
    .flag_i    (flag),
    .mode_i    (ctrl_q.mode),
    .rst_en_i  (ctrl_q.rst_en),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[FLAG_BIT]  = flag;
    ctrl_word[MODE_BIT]  = ctrl_q.mode;
    ctrl_word[EN_BIT]    = ctrl_q.en;
    ctrl_word[RSTEN_BIT] = ctrl_q.rst_en;
  end

  assign rdata_o = (addr_i == ADDR_CTRL) ? ctrl_word : cnt;
endmodule

// File: rtl/wdog_itmr_chk.sv
module wdog_itmr_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             req_i,
  input logic             we_i,
  input logic             addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic             irq_o,
  input logic             nmi_o,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             armed,
  input logic             en,
  input logic             cnt_wr,
  input logic             ctrl_wr
);
  import wdog_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_wrap;
  assign at_wrap = en && tick_i && (cnt == CNT_MAX) && !cnt_wr;

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_wrap |=> flag); // R4
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(en && tick_i) && !cnt_wr) |=> $stable(cnt)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt == $past(wdata_i))); // R3
  AST_NO_CLR_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && ctrl_wr && !armed && wdata_i[EN_BIT] && !rst_req_o) |=> flag); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_wrap && ctrl_wr) |=> flag); // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[EN_BIT] && !at_wrap) |=> !flag); // R8
  AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i && irq_o) |-> (rdata_o[FLAG_BIT] && !rdata_o[MODE_BIT])); // R9
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> (!rst_req_o && !flag)); // R10
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_req_o, nmi_o})); // R10
  AST_NMI_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o); // R11
endmodule

bind wdog_itmr wdog_itmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .nmi_o     (nmi_o),
  .rst_req_o (rst_req_o),
  .cnt       (cnt),
  .flag      (flag),
  .armed     (armed),
  .en        (ctrl_q.en),
  .cnt_wr    (cnt_wr),
  .ctrl_wr   (ctrl_wr)
);

// File: tb/wdog_itmr_bench.sv
module wdog_itmr_bench;
  localparam real HALF = 2.5;
  localparam logic [7:0] FLG = 8'h80, MOD = 8'h40, ENB = 8'h20, RSE = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq, nmi, rst_req;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #(HALF) clk = ~clk;

  wdog_itmr u_wdog_itmr (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .nmi_o(nmi), .rst_req_o(rst_req)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  // counter at 0xFF, flag cleared, control word as given
  task automatic prime(input logic [7:0] c);
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b0, 8'hFF);
    bus_wr(1'b1, c);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq", irq, 0); chk("R1 nmi", nmi, 0); chk("R1 rst", rst_req, 0);
    bus_rd(1'b0, rv); chk("R1 cnt", rv, 8'h00);
    bus_rd(1'b1, rv); chk("R1 ctrl", rv, 8'h00);

    // R12 layout
    bus_wr(1'b1, 8'h7F); bus_rd(1'b1, rv); chk("R12 rw bits", rv, 8'h70);
    bus_wr(1'b1, 8'h0F); bus_rd(1'b1, rv); chk("R12 low bits", rv, 8'h00);

    // R2 disabled: ticks ignored
    bus_wr(1'b0, 8'h10); tick_n(5); bus_rd(1'b0, rv); chk("R2 disabled", rv, 8'h10);
    // R2 enabled, no ticks
    bus_wr(1'b1, ENB); repeat (6) @(negedge clk);
    bus_rd(1'b0, rv); chk("R2 no tick", rv, 8'h10);

    // R3 load beats count
    @(negedge clk); tick = 1'b1; req = 1'b1; we = 1'b1; addr = 1'b0; wdata = 8'h40;
    @(negedge clk); tick = 1'b0; req = 1'b0; we = 1'b0;
    bus_rd(1'b0, rv); chk("R3 load", rv, 8'h40);
    // R3 load of 0x00 while at 0xFF with tick: no overflow
    prime(ENB);
    @(negedge clk); tick = 1'b1; req = 1'b1; we = 1'b1; addr = 1'b0; wdata = 8'h00;
    @(negedge clk); tick = 1'b0; req = 1'b0; we = 1'b0;
    bus_rd(1'b1, rv); chk("R3 no ovf on load", rv, ENB);

    // sweep of every start value, interval mode (R2 R4 R9)
    for (int s = 0; s < 256; s++) begin
      int n, sum;
      n = 1 + (s * 37) % 280;
      sum = s + n;
      bus_wr(1'b1, 8'h00);
      bus_wr(1'b0, s[7:0]);
      bus_wr(1'b1, ENB);
      tick_n(n);
      bus_rd(1'b0, rv); chk("R2 count", rv, sum % 256);
      #1 chk("R9 irq", irq, sum > 255);
      bus_rd(1'b1, rv); chk("R4 flag", rv[7], sum > 255);
    end

    // R6 read at set cycle returns 0 and does not arm
    prime(ENB);
    @(negedge clk); tick = 1'b1; req = 1'b1; we = 1'b0; addr = 1'b1;
    #1 chk("R6 same-cycle read", rdata, ENB);
    @(negedge clk); tick = 1'b0; req = 1'b0;
    bus_wr(1'b1, ENB);
    bus_rd(1'b1, rv); chk("R6 not armed", rv, FLG | ENB);
    // R5 write of 1 drops the arm
    bus_wr(1'b1, FLG | ENB); bus_wr(1'b1, ENB);
    bus_rd(1'b1, rv); chk("R5 arm dropped", rv, FLG | ENB);
    bus_wr(1'b1, ENB);
    bus_rd(1'b1, rv); chk("R5 armed clear", rv, ENB);
    bus_wr(1'b1, FLG | ENB);
    bus_rd(1'b1, rv); chk("R5 write 1", rv, ENB);

    // R7 set beats armed clear
    prime(ENB); tick_n(1);
    bus_rd(1'b1, rv); chk("R7 setup", rv, FLG | ENB);
    bus_wr(1'b0, 8'hFF);
    @(negedge clk); tick = 1'b1; req = 1'b1; we = 1'b1; addr = 1'b1; wdata = ENB;
    @(negedge clk); tick = 1'b0; req = 1'b0; we = 1'b0;
    bus_rd(1'b1, rv); chk("R7 set wins", rv, FLG | ENB);
    // R7 set beats disable write
    bus_wr(1'b1, ENB); bus_wr(1'b0, 8'hFF);
    @(negedge clk); tick = 1'b1; req = 1'b1; we = 1'b1; addr = 1'b1; wdata = 8'h00;
    @(negedge clk); tick = 1'b0; req = 1'b0; we = 1'b0;
    bus_rd(1'b1, rv); chk("R7 set vs disable", rv, FLG);

    // R8 disable clears without read
    prime(ENB); tick_n(1);
    bus_wr(1'b1, 8'h00);
    bus_rd(1'b1, rv); chk("R8 disable clear", rv, 8'h00);

    // R10 watchdog reset
    prime(MOD | ENB | RSE);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1 chk("R10 rst pulse", rst_req, 1); chk("R10 no nmi", nmi, 0);
    @(negedge clk);
    #1 chk("R10 rst one cycle", rst_req, 0);
    bus_rd(1'b1, rv); chk("R10 flag auto clear", rv, MOD | ENB | RSE);

    // R11 watchdog NMI
    prime(MOD | ENB);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1 chk("R11 nmi pulse", nmi, 1); chk("R11 no rst", rst_req, 0);
    @(negedge clk);
    #1 chk("R11 nmi one cycle", nmi, 0); chk("R9 no irq in watchdog", irq, 0);
    bus_rd(1'b1, rv); chk("R11 flag kept", rv, FLG | MOD | ENB);

    finish_run();
  end
endmodule